// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block deserialises stereo PCM audio carried on a bit clock, a word clock (or frame sync) and one data line. It understands four framing conventions: I2S, left-justified, right-justified and a DSP-style frame-sync format. It accepts 24-, 20- and 16-bit words. The block is clocked by the bit clock itself. Its output is one left/right sample pair per frame, in 24-bit two's complement form, marked by a single-cycle strobe.

The framing convention and the word length come from static configuration inputs. Each new setting is picked up at the start of the next left word, so a frame already in flight keeps the setting it started with. Shorter words are placed at the top of the 24-bit output and the unused low bits are zero. In the frame-sync format the line carries no channel information. The block therefore assigns words to the two channels by alternation, starting with left after reset.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset `valid_o` is low and both sample outputs are zero.
- R2: With mode code 000 (I2S), data is sampled on the rising bit-clock edge. Word clock low marks the left word and high marks the right word. The MSB sits in the bit period that follows each word-clock change.
- R3: With mode code 011 (left-justified), data is sampled on the rising edge. Word clock high marks the left word. The MSB sits in the same bit period as the word-clock change.
- R4: With mode code 001 (right-justified), word clock high marks the left word. The LSB sits in the last bit period before the next word-clock change. With 32 bit periods per half-frame, the MSB therefore follows the change by 8, 12 or 16 periods for 24-, 20- or 16-bit words.
- R5: With mode code 010 (frame sync), data is sampled on the falling bit-clock edge. A rising frame sync starts a word and the MSB sits in the following bit period. The sync may stay high beyond the MSB. Successive words go to left, then right, alternating from reset.
- R6: Width code 00 selects 24 bits, 01 selects 20 bits and 10 selects 16 bits. Code 11 is taken as 24 bits. Words shorter than 24 bits appear left-aligned with zero low bits.
- R7: `valid_o` is high for exactly one cycle per frame. It rises in the cycle after the last bit of the right word is processed, and it carries that frame's left and right words together. A right word with no preceding left word produces no strobe.
- R8: The sample outputs hold their value in every cycle in which `valid_o` is low.
- R9: Mode and width inputs are taken up at the start of a left word. A change during a frame leaves that frame's decoding unaffected.
- R10: Mode codes with the top bit set decode nothing, and `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all logic runs on it |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ws_i | input | 1 | Word clock or frame sync |
| sd_i | input | 1 | Serial data, MSB first |
| mode_i | input | 3 | Framing mode code |
| width_i | input | 2 | Word length code |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |

## Verification
Two events can fall in the same cycle at a frame boundary. In right-justified mode, the right word's last bit is processed one period before the next left anchor, which reloads the configuration. A width change driven in the middle of the right word therefore lands in the cycle that follows completion. The bench provokes this by changing the width code during a right word. Its behavioural model expects the old width for the finishing frame and the new width only from the next left word. Every cycle it compares strobe, left and right against the model's held values.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S = 3'b000,
    FMT_RJ  = 3'b001,
    FMT_DSP = 3'b010,
    FMT_LJ  = 3'b011
  } fmt_e;

  // Word length in bits for a width code; the reserved code maps to 24.
  function automatic int unsigned word_len(input logic [1:0] code);
    case (code)
      2'b01:   word_len = 20;
      2'b10:   word_len = 16;
      default: word_len = 24;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sampler.sv
module aud_rx_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  input  logic sd_i,
  input  logic neg_sel_i,
  output logic ws_o,
  output logic sd_o
);

  logic ws_neg_q, sd_neg_q;

  // Falling-edge capture for the frame-sync format
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_neg_q <= 1'b0;
      sd_neg_q <= 1'b0;
    end else begin
      ws_neg_q <= ws_i;
      sd_neg_q <= sd_i;
    end
  end

  always_comb begin
    ws_o = neg_sel_i ? ws_neg_q : ws_i;
    sd_o = neg_sel_i ? sd_neg_q : sd_i;
  end

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned SAMPLE_W  = 24,
  localparam int unsigned CNT_W    = $clog2(2 * SLOT_BITS),
  localparam int unsigned IDX_W    = $clog2(SAMPLE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ws_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       width_i,
  output logic             cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             chan_r_o,
  output logic [2:0]       mode_q_o,
  output logic [1:0]       width_q_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] SLOT_C  = CNT_W'(SLOT_BITS);

  logic             ws_q, act_q, tog_q, chan_q;
  logic [CNT_W-1:0] pos_q;
  fmt_e             mode_q;
  logic [1:0]       width_q;

  logic             ws_q_n, act_n, tog_n, chan_n;
  logic [CNT_W-1:0] pos_n;
  fmt_e             mode_n;
  logic [1:0]       width_n;

  logic             anchor, anc_r, load, supported;
  logic [CNT_W-1:0] wlen, off, rel;

  always_comb begin
    anchor = 1'b0;
    anc_r  = 1'b0;
    case (mode_q)
      FMT_I2S:        begin anchor = ws_i ^ ws_q;   anc_r = ws_i;  end
      FMT_LJ, FMT_RJ: begin anchor = ws_i ^ ws_q;   anc_r = ~ws_i; end
      FMT_DSP:        begin anchor = ws_i & ~ws_q;  anc_r = tog_q; end
      default:        ;
    endcase

    // configuration is reloaded at a left word start or while idle
    load    = (anchor & ~anc_r) | ~act_q;
    mode_n  = load ? fmt_e'(mode_i) : mode_q;
    width_n = load ? width_i : width_q;

    wlen = CNT_W'(word_len(width_n));
    case (mode_n)
      FMT_LJ:  off = '0;
      FMT_RJ:  off = SLOT_C - wlen;
      default: off = CNT_W'(1);
    endcase
    supported = ~mode_n[2];

    ws_q_n = ws_i;
    pos_n  = anchor ? '0 : ((pos_q == CNT_MAX) ? pos_q : pos_q + 1'b1);
    chan_n = anchor ? anc_r : chan_q;
    act_n  = act_q | anchor;
    tog_n  = (anchor && mode_q == FMT_DSP) ? ~tog_q : tog_q;

    rel    = pos_n - off;
    cap_o  = act_n & supported & (pos_n >= off) & (pos_n < off + wlen);
    idx_o  = rel[IDX_W-1:0];
    done_o = cap_o & (rel == wlen - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q    <= 1'b0;
      act_q   <= 1'b0;
      tog_q   <= 1'b0;
      chan_q  <= 1'b0;
      pos_q   <= '0;
      mode_q  <= FMT_I2S;
      width_q <= 2'b00;
    end else begin
      ws_q    <= ws_q_n;
      act_q   <= act_n;
      tog_q   <= tog_n;
      chan_q  <= chan_n;
      pos_q   <= pos_n;
      mode_q  <= mode_n;
      width_q <= width_n;
    end
  end

  assign chan_r_o  = chan_n;
  assign mode_q_o  = mode_q;
  assign width_q_o = width_q;

endmodule

// File: rtl/aud_rx_assembler.sv
module aud_rx_assembler #(
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sd_i,
  input  logic                cap_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                done_i,
  input  logic                chan_r_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] sreg_q, sreg_n, hold_q, hold_n, left_n, right_n;
  logic                have_l_q, have_l_n, valid_n;
  logic [IDX_W-1:0]    bitpos;

  always_comb begin
    bitpos   = TOP - idx_i;
    sreg_n   = sreg_q;
    hold_n   = hold_q;
    have_l_n = have_l_q;
    left_n   = left_o;
    right_n  = right_o;
    valid_n  = 1'b0;
    if (cap_i) begin
      if (idx_i == '0) sreg_n = '0;
      sreg_n[bitpos] = sd_i;
    end
    if (done_i && !chan_r_i) begin
      hold_n   = sreg_n;
      have_l_n = 1'b1;
    end else if (done_i && chan_r_i && have_l_q) begin
      left_n   = hold_q;
      right_n  = sreg_n;
      valid_n  = 1'b1;
      have_l_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      hold_q   <= '0;
      have_l_q <= 1'b0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      sreg_q   <= sreg_n;
      hold_q   <= hold_n;
      have_l_q <= have_l_n;
      left_o   <= left_n;
      right_o  <= right_n;
      valid_o  <= valid_n;
    end
  end

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned SAMPLE_W  = 24,
  localparam int unsigned IDX_W    = $clog2(SAMPLE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [2:0]          mode_i,
  input  logic [1:0]          width_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             ws_s, sd_s, cap, done, chan_r;
  logic [IDX_W-1:0] idx;
  logic [2:0]       cur_mode;
  logic [1:0]       cur_width;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  aud_rx_sampler u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .neg_sel_i (cur_mode == FMT_DSP),
    .ws_o      (ws_s),
    .sd_o      (sd_s)
  );

  aud_rx_framer #(.SLOT_BITS(SLOT_BITS), .SAMPLE_W(SAMPLE_W)) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .ws_i      (ws_s),
    .mode_i    (mode_i),
    .width_i   (width_i),
    .cap_o     (cap),
    .idx_o     (idx),
    .done_o    (done),
    .chan_r_o  (chan_r),
    .mode_q_o  (cur_mode),
    .width_q_o (cur_width)
  );

  aud_rx_assembler #(.SAMPLE_W(SAMPLE_W)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sd_i     (sd_s),
    .cap_i    (cap),
    .idx_i    (idx),
    .done_i   (done),
    .chan_r_i (chan_r),
    .valid_o  (valid_o),
    .left_o   (left_o),
    .right_o  (right_o)
  );

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic                valid,
  input logic [SAMPLE_W-1:0] left,
  input logic [SAMPLE_W-1:0] right,
  input logic [2:0]          mode_cur,
  input logic [1:0]          width_cur
);

  assert_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid |=> !valid);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !valid |-> ($stable(left) && $stable(right)));

  assert_low16_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid && width_cur == 2'b10) |-> (left[7:0] == 8'h00 && right[7:0] == 8'h00));

  assert_low20_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid && width_cur == 2'b01) |-> (left[3:0] == 4'h0 && right[3:0] == 4'h0));

  assert_unsupported_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_cur[2] && $past(mode_cur[2])) |-> !valid);

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .valid     (valid_o),
  .left      (left_o),
  .right     (right_o),
  .mode_cur  (cur_mode),
  .width_cur (cur_width)
);

// File: tb/tb_aud_serial_rx.sv
`timescale 1ns/1ps
module tb_aud_serial_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws = 1'b0, sd = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [1:0]  width = 2'b00;
  logic        valid_o;
  logic [23:0] left_o, right_o;

  int          cyc = 0, vecs = 0, fails = 0;
  bit          finished = 0;
  string       cur_req = "R1";
  int          q_cyc[$];
  logic [23:0] q_l[$], q_r[$];
  logic [23:0] held_l = '0, held_r = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aud_serial_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .ws_i(ws), .sd_i(sd),
    .mode_i(mode), .width_i(width),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
  );

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic exp_v;
      exp_v = 1'b0;
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        exp_v = 1'b1;
        held_l = q_l.pop_front();
        held_r = q_r.pop_front();
        void'(q_cyc.pop_front());
      end
      vecs++;
      if (valid_o !== exp_v || left_o !== held_l || right_o !== held_r) begin
        fails++;
        $display("FAIL %s cyc %0d: valid/left/right = %b/%h/%h expected %b/%h/%h",
                 cur_req, cyc, valid_o, left_o, right_o, exp_v, held_l, held_r);
      end
    end
  end

  function automatic int wl(input logic [1:0] c);
    return (c == 2'b01) ? 20 : (c == 2'b10) ? 16 : 24;
  endfunction

  function automatic logic [23:0] align(input logic [23:0] v, input int w);
    return (v >> (24 - w)) << (24 - w);
  endfunction

  task automatic drive(input logic w, input logic b, input bit dsp);
    if (dsp) begin @(posedge clk); #1; end
    else @(negedge clk);
    ws = w;
    sd = b;
  endtask

  task automatic do_reset(input logic [2:0] m, input logic [1:0] wc);
    rst_n = 1'b0;
    mode = m; width = wc; ws = 1'b0; sd = 1'b0;
    q_cyc.delete(); q_l.delete(); q_r.delete();
    held_l = '0; held_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n, input logic w, input bit dsp);
    for (int i = 0; i < n; i++) drive(w, 1'b1, dsp);
  endtask

  // One 64-period frame; m is the layout, wc the width the frame was started with.
  task automatic send_frame(input int m, input logic [1:0] wc,
                            input logic [23:0] lv, input logic [23:0] rv,
                            input bit expect_out, input int chg_at,
                            input logic [1:0] chg_wc);
    int w;
    w = wl(wc);
    for (int p = 0; p < 64; p++) begin
      bit rgt;
      int q, k;
      logic wsv, b;
      logic [23:0] v;
      rgt = (p >= 32);
      q = p % 32;
      v = rgt ? rv : lv;
      case (m)
        0:       begin wsv = rgt;      k = q - 1;        end
        3:       begin wsv = !rgt;     k = q;            end
        1:       begin wsv = !rgt;     k = q - (32 - w); end
        default: begin wsv = (q < 2);  k = q - 1;        end
      endcase
      b = (k >= 0 && k < w) ? v[23 - k] : 1'b1;
      drive(wsv, b, m == 2);
      if (p == chg_at) width = chg_wc;
      if (rgt && k == w - 1 && expect_out) begin
        q_cyc.push_back(cyc + 1);
        q_l.push_back(align(lv, w));
        q_r.push_back(align(rv, w));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset(3'b000, 2'b00);
    vecs++;
    if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
      fails++;
      $display("FAIL R1: valid/left/right = %b/%h/%h expected 0/000000/000000",
               valid_o, left_o, right_o);
    end

    // R2 I2S and R7 (junk right word before any left word gives no strobe)
    cur_req = "R2 R7 I2S";
    idle(40, 1'b1, 0);
    send_frame(0, 2'b00, 24'h123456, 24'hABCDEF, 1, -1, 2'b00);
    send_frame(0, 2'b00, 24'h800000, 24'h7FFFFF, 1, -1, 2'b00);
    send_frame(0, 2'b00, 24'h000001, 24'hFFFFFE, 1, -1, 2'b00);
    cur_req = "R6 reserved width in I2S";
    width = 2'b11;
    send_frame(0, 2'b11, 24'h5A5A5A, 24'hC3C3C3, 1, -1, 2'b11);
    send_frame(0, 2'b11, 24'h0F0F0F, 24'hF0F0F0, 1, -1, 2'b11);

    // R3 left-justified, R9 width change mid-frame
    do_reset(3'b011, 2'b00);
    cur_req = "R3 LJ 24";
    idle(20, 1'b0, 0);
    send_frame(3, 2'b00, 24'h13579B, 24'h2468AC, 1, -1, 2'b00);
    cur_req = "R9 width change during a frame";
    send_frame(3, 2'b00, 24'hFEDCBA, 24'h987654, 1, 40, 2'b10);
    cur_req = "R6 R3 LJ 16";
    send_frame(3, 2'b10, 24'hBEEF77, 24'h1234FF, 1, -1, 2'b10);
    send_frame(3, 2'b10, 24'h8001AA, 24'h7FFE55, 1, -1, 2'b10);

    // R4 right-justified, widths 20 and 16
    do_reset(3'b001, 2'b01);
    cur_req = "R4 R6 RJ 20";
    idle(20, 1'b0, 0);
    send_frame(1, 2'b01, 24'hABCDE0, 24'h12345F, 1, -1, 2'b01);
    send_frame(1, 2'b01, 24'h800000, 24'hFFFFF0, 1, 50, 2'b10);
    cur_req = "R4 R9 RJ 16";
    send_frame(1, 2'b10, 24'hCAFE00, 24'h0BAD00, 1, -1, 2'b10);
    cur_req = "R4 RJ 24";
    width = 2'b00;
    send_frame(1, 2'b00, 24'h765432, 24'h89ABCD, 1, -1, 2'b00);

    // R5 frame-sync format, falling-edge sampling and alternation
    do_reset(3'b010, 2'b00);
    cur_req = "R5 DSP 24";
    idle(20, 1'b0, 1);
    send_frame(2, 2'b00, 24'hA1B2C3, 24'h4D5E6F, 1, -1, 2'b00);
    send_frame(2, 2'b00, 24'h7FFFFF, 24'h800001, 1, -1, 2'b00);
    cur_req = "R5 R6 DSP 20";
    width = 2'b01;
    send_frame(2, 2'b01, 24'h3C3C30, 24'hE1E1E0, 1, -1, 2'b01);

    // R10 unsupported mode
    do_reset(3'b101, 2'b00);
    cur_req = "R10 unsupported mode";
    idle(20, 1'b0, 0);
    send_frame(3, 2'b00, 24'h111111, 24'h222222, 0, -1, 2'b00);
    send_frame(1, 2'b00, 24'h333333, 24'h444444, 0, -1, 2'b00);

    idle(8, 1'b0, 0);
    vecs++;
    if (q_cyc.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d strobes missing, expected 0", q_cyc.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule